// File: doc/BRIEF.md
# Operand Swizzle and Write-Mask Unit

This block prepares the two source operands of a vector instruction, each made of four 24-bit components. It holds a small loadable table of operand-descriptor words. Every instruction names one entry of the table by a short id. That entry supplies two things: a component selector for each lane of both operands, and the lane write enables for the destination.

The block decodes the two source register indices into a register file and a row. It drives the row to the register files and takes their read data back in the same cycle. It then permutes the components of each operand and registers the result. The operands, the write enables, the carried destination index and an invalid-operand flag appear one cycle after the issue strobe. No arithmetic is done here.

The table is filled through a small write port. One address rewinds the fill pointer. Eight further addresses all behave as the same data port, and every write there stores one descriptor and advances the pointer.

Top module: `osw_unit`

## Requirements
- R1: A write to `cfg_addr` 0 sets the fill pointer to entry 0. A write to any data address stores `cfg_wdata` in the entry under the pointer and then advances the pointer by one, wrapping from the last entry (31 by default) back to 0.
- R2: `cfg_addr` values 1 to 8 behave identically as the data port. Writes to `cfg_addr` 9 to 15 change neither the table nor the pointer.
- R3: An issue looks up the entry named by `desc_id`. If that entry is written in the same cycle, the lookup returns its contents from before the write.
- R4: `src1_idx` decodes as follows. Below 0x10 it reads the input file at row idx. From 0x10 to 0x1F it reads the temporary file at row idx-0x10. From 0x20 up it reads the uniform file at row idx-0x20. `src1_row` carries that row.
- R5: A `src1_idx` whose uniform row idx-0x20 is not below NUM_UNI (default 64, so 0x60 to 0x7F) yields an all-zero `op1` and raises `bad_src1` together with `op_valid`. `bad_src1` is low in every other cycle.
- R6: `src2_idx` (5 bits) below 0x10 reads the input file at row idx. Any other value reads the temporary file at row idx-0x10. `src2_row` carries that row.
- R7: A 2-bit selector picks the source component for each output lane: 0 picks x, 1 picks y, 2 picks z, 3 picks w. The source-1 selectors for lanes 0..3 are at descriptor bits [12:11], [10:9], [8:7] and [6:5]. The source-2 selectors are at [21:20], [19:18], [17:16] and [15:14]. Lane c (0=x) occupies vector bits [24c+23:24c], both in the read data and in `op1` and `op2`.
- R8: `wr_en[c]` equals descriptor bit 3-c, so bit 3 enables x and bit 0 enables w. `wr_en` is zero whenever `op_valid` is low.
- R9: `op_valid` is high exactly in the cycle after a cycle with `issue_vld` high. In that cycle `op_dst` shows the `dst_idx` that was issued.
- R10: After reset the table holds zeros, the pointer is 0, and `op_valid`, `wr_en`, `bad_src1`, `op1` and `op2` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Table port write strobe |
| cfg_addr | input | 4 | 0 rewinds the pointer, 1..8 carry data, others are ignored |
| cfg_wdata | input | 22 | Descriptor word to store |
| issue_vld | input | 1 | Instruction issue strobe |
| desc_id | input | 5 | Descriptor table entry to use |
| src1_idx | input | 7 | Source-1 register index |
| src2_idx | input | 5 | Source-2 register index |
| dst_idx | input | 7 | Destination index, carried through |
| src1_row | output | 6 | Row driven to the register files for source 1 |
| src2_row | output | 4 | Row driven to the register files for source 2 |
| in_rd1 | input | 96 | Input file read data at `src1_row` |
| tmp_rd1 | input | 96 | Temporary file read data at `src1_row` |
| uni_rd1 | input | 96 | Uniform file read data at `src1_row` |
| in_rd2 | input | 96 | Input file read data at `src2_row` |
| tmp_rd2 | input | 96 | Temporary file read data at `src2_row` |
| op_valid | output | 1 | Result strobe, one cycle after issue |
| op1 | output | 96 | Swizzled source-1 operand |
| op2 | output | 96 | Swizzled source-2 operand |
| wr_en | output | 4 | Destination lane write enables, bit 0 = x |
| op_dst | output | 7 | Destination index of the result |
| bad_src1 | output | 1 | Source-1 index had no valid decode |

## Verification
The hardest case to reach from the ports is a table state that depends on pointer history: a wrap past the last entry, a rewind in the middle of a fill, and a lookup of an entry in the very cycle it is rewritten. The stimulus builds these states deliberately. It fills all 32 entries and then writes once more. It rewinds partway through a fill. It interleaves ignored addresses with data writes. It issues the entry under the pointer in the same cycle as its write. The register files in the bench return a distinct value for every file, row and lane, so a wrong file, a wrong row or a wrong selector each produces a visible mismatch.

// File: rtl/osw_pkg.sv
package osw_pkg;

  // Descriptor word width: the highest field ends at bit 21.
  localparam int DESC_W = 22;
  localparam int LANES  = 4;

  typedef enum logic [1:0] {
    SRC_IN  = 2'd0,
    SRC_TMP = 2'd1,
    SRC_UNI = 2'd2,
    SRC_BAD = 2'd3
  } src_kind_e;

  // Low bit of the source-1 selector for lane c: lane 0 at [12:11]
  function automatic int s1_sel_lo(input int c);
    return 11 - 2 * c;
  endfunction

  // Low bit of the source-2 selector for lane c: lane 0 at [21:20]
  function automatic int s2_sel_lo(input int c);
    return 20 - 2 * c;
  endfunction

  // Mask bit that enables lane c: bit 3 is lane x
  function automatic int mask_bit(input int c);
    return 3 - c;
  endfunction

endpackage

// File: rtl/osw_desc_table.sv
module osw_desc_table
  import osw_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int ID_W = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld_begin,
  input  logic                  ld_data,
  input  logic [DESC_W-1:0]     ld_word,
  input  logic [ID_W-1:0]       rd_id,
  output logic [3:0]            rd_mask,
  output logic [LANES-1:0][1:0] rd_sel1,
  output logic [LANES-1:0][1:0] rd_sel2,
  output logic [ID_W-1:0]       ptr_q
);

  logic [DESC_W-1:0] tbl_q [DEPTH];
  logic [ID_W-1:0]   ptr_nxt;

  assign ptr_nxt = (ptr_q == ID_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
    end else if (ld_begin) begin
      ptr_q <= '0;
    end else if (ld_data) begin
      tbl_q[ptr_q] <= ld_word;
      ptr_q        <= ptr_nxt;
    end
  end

  // Field extraction straight from the addressed entry (read before write)
  assign rd_mask = tbl_q[rd_id][3:0];

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    assign rd_sel1[c] = tbl_q[rd_id][s1_sel_lo(c) +: 2];
    assign rd_sel2[c] = tbl_q[rd_id][s2_sel_lo(c) +: 2];
  end

endmodule

// File: rtl/osw_src_decode.sv
module osw_src_decode
  import osw_pkg::*;
#(
  parameter int IDX_W   = 7,
  parameter bit HAS_UNI = 1'b1,
  parameter int NUM_UNI = 64,
  parameter int ROW_W   = 6
) (
  input  logic [IDX_W-1:0] idx,
  output src_kind_e        kind,
  output logic [ROW_W-1:0] row
);

  localparam int IN_LIM  = 16;
  localparam int TMP_LIM = 32;

  if (HAS_UNI) begin : g_uni
    logic [IDX_W-1:0] uoff;
    assign uoff = idx - IDX_W'(TMP_LIM);

    always_comb begin
      if (idx < IDX_W'(IN_LIM))        kind = SRC_IN;
      else if (idx < IDX_W'(TMP_LIM))  kind = SRC_TMP;
      else if (uoff < IDX_W'(NUM_UNI)) kind = SRC_UNI;
      else                             kind = SRC_BAD;
    end

    // Input and temporary rows are both the low four index bits
    assign row = (idx < IDX_W'(TMP_LIM)) ? ROW_W'(idx[3:0]) : uoff[ROW_W-1:0];
  end else begin : g_no_uni
    assign kind = (idx < IDX_W'(IN_LIM)) ? SRC_IN : SRC_TMP;
    assign row  = ROW_W'(idx[3:0]);
  end

endmodule

// File: rtl/osw_swizzle.sv
module osw_swizzle
  import osw_pkg::*;
#(
  parameter int COMP_W = 24,
  localparam int VEC_W = LANES * COMP_W
) (
  input  logic [VEC_W-1:0]      vec_in,
  input  logic [LANES-1:0][1:0] sel,
  output logic [VEC_W-1:0]      vec_out
);

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    assign vec_out[c*COMP_W +: COMP_W] = vec_in[sel[c]*COMP_W +: COMP_W];
  end

endmodule

// File: rtl/osw_unit.sv
module osw_unit
  import osw_pkg::*;
#(
  parameter int COMP_W    = 24,
  parameter int TBL_DEPTH = 32,
  parameter int NUM_UNI   = 64,
  localparam int VEC_W     = LANES * COMP_W,
  localparam int ID_W      = $clog2(TBL_DEPTH),
  localparam int UNI_ROW_W = $clog2(NUM_UNI),
  localparam int S1_ROW_W  = (UNI_ROW_W > 4) ? UNI_ROW_W : 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_addr,
  input  logic [DESC_W-1:0] cfg_wdata,
  input  logic              issue_vld,
  input  logic [ID_W-1:0]   desc_id,
  input  logic [6:0]        src1_idx,
  input  logic [4:0]        src2_idx,
  input  logic [6:0]        dst_idx,
  output logic [S1_ROW_W-1:0] src1_row,
  output logic [3:0]        src2_row,
  input  logic [VEC_W-1:0]  in_rd1,
  input  logic [VEC_W-1:0]  tmp_rd1,
  input  logic [VEC_W-1:0]  uni_rd1,
  input  logic [VEC_W-1:0]  in_rd2,
  input  logic [VEC_W-1:0]  tmp_rd2,
  output logic              op_valid,
  output logic [VEC_W-1:0]  op1,
  output logic [VEC_W-1:0]  op2,
  output logic [3:0]        wr_en,
  output logic [6:0]        op_dst,
  output logic              bad_src1
);

  // Named internal events used by the checker
  logic                  ld_begin;
  logic                  ld_data;
  logic [ID_W-1:0]       tbl_ptr;
  logic [3:0]            d_mask;
  logic [LANES-1:0][1:0] d_sel1;
  logic [LANES-1:0][1:0] d_sel2;
  logic [3:0]            lane_wen;
  src_kind_e             kind1;
  src_kind_e             kind2;
  logic [VEC_W-1:0]      raw1, raw2, swz1, swz2;

  assign ld_begin = cfg_wr && (cfg_addr == 4'd0);
  assign ld_data  = cfg_wr && (cfg_addr >= 4'd1) && (cfg_addr <= 4'd8);

  osw_desc_table #(.DEPTH(TBL_DEPTH)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_begin(ld_begin),
    .ld_data (ld_data),
    .ld_word (cfg_wdata),
    .rd_id   (desc_id),
    .rd_mask (d_mask),
    .rd_sel1 (d_sel1),
    .rd_sel2 (d_sel2),
    .ptr_q   (tbl_ptr)
  );

  osw_src_decode #(
    .IDX_W(7), .HAS_UNI(1'b1), .NUM_UNI(NUM_UNI), .ROW_W(S1_ROW_W)
  ) u_dec1 (
    .idx (src1_idx),
    .kind(kind1),
    .row (src1_row)
  );

  osw_src_decode #(
    .IDX_W(5), .HAS_UNI(1'b0), .NUM_UNI(NUM_UNI), .ROW_W(4)
  ) u_dec2 (
    .idx (src2_idx),
    .kind(kind2),
    .row (src2_row)
  );

  always_comb begin
    unique case (kind1)
      SRC_IN:  raw1 = in_rd1;
      SRC_TMP: raw1 = tmp_rd1;
      SRC_UNI: raw1 = uni_rd1;
      default: raw1 = '0;
    endcase
    raw2 = (kind2 == SRC_IN) ? in_rd2 : tmp_rd2;
  end

  osw_swizzle #(.COMP_W(COMP_W)) u_swz1 (
    .vec_in (raw1),
    .sel    (d_sel1),
    .vec_out(swz1)
  );

  osw_swizzle #(.COMP_W(COMP_W)) u_swz2 (
    .vec_in (raw2),
    .sel    (d_sel2),
    .vec_out(swz2)
  );

  for (genvar c = 0; c < LANES; c++) begin : g_wen
    assign lane_wen[c] = d_mask[mask_bit(c)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op1      <= '0;
      op2      <= '0;
      wr_en    <= '0;
      op_dst   <= '0;
      bad_src1 <= 1'b0;
    end else begin
      op_valid <= issue_vld;
      if (issue_vld) begin
        op1      <= swz1;
        op2      <= swz2;
        wr_en    <= lane_wen;
        op_dst   <= dst_idx;
        bad_src1 <= (kind1 == SRC_BAD);
      end else begin
        wr_en    <= '0;
        bad_src1 <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/osw_unit_chk.sv
module osw_unit_chk #(
  parameter int VEC_W = 96,
  parameter int DEPTH = 32,
  parameter int PTR_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_vld,
  input logic             op_valid,
  input logic [3:0]       wr_en,
  input logic             bad_src1,
  input logic [VEC_W-1:0] op1,
  input logic             ld_begin,
  input logic             ld_data,
  input logic [PTR_W-1:0] ptr
);

  assert_vld_follows_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |=> op_valid);

  assert_vld_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> !op_valid);

  assert_wen_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (wr_en == 4'd0));

  assert_bad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_src1 |-> (op_valid && (op1 == '0)));

  assert_begin_rewinds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_begin |=> (ptr == '0));

  assert_ptr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_data && !ld_begin) |=>
      (ptr == (($past(ptr) == PTR_W'(DEPTH - 1)) ? '0 : $past(ptr) + 1'b1)));

  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_data && !ld_begin) |=> $stable(ptr));

endmodule

bind osw_unit osw_unit_chk #(
  .VEC_W(VEC_W), .DEPTH(TBL_DEPTH), .PTR_W(ID_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .issue_vld(issue_vld),
  .op_valid (op_valid),
  .wr_en    (wr_en),
  .bad_src1 (bad_src1),
  .op1      (op1),
  .ld_begin (ld_begin),
  .ld_data  (ld_data),
  .ptr      (tbl_ptr)
);

// File: tb/osw_unit_test.sv
module osw_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [21:0] cfg_wdata = '0;
  logic        issue_vld = 1'b0;
  logic [4:0]  desc_id = '0;
  logic [6:0]  src1_idx = '0;
  logic [4:0]  src2_idx = '0;
  logic [6:0]  dst_idx = '0;
  logic [5:0]  src1_row;
  logic [3:0]  src2_row;
  logic [95:0] in_rd1, tmp_rd1, uni_rd1, in_rd2, tmp_rd2;
  logic        op_valid;
  logic [95:0] op1, op2;
  logic [3:0]  wr_en;
  logic [6:0]  op_dst;
  logic        bad_src1;

  always #5 clk = ~clk;

  osw_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .issue_vld(issue_vld), .desc_id(desc_id),
    .src1_idx(src1_idx), .src2_idx(src2_idx), .dst_idx(dst_idx),
    .src1_row(src1_row), .src2_row(src2_row), .in_rd1(in_rd1),
    .tmp_rd1(tmp_rd1), .uni_rd1(uni_rd1), .in_rd2(in_rd2), .tmp_rd2(tmp_rd2),
    .op_valid(op_valid), .op1(op1), .op2(op2), .wr_en(wr_en),
    .op_dst(op_dst), .bad_src1(bad_src1)
  );

  // Register file models: every file, row and lane gives a distinct value
  function automatic logic [23:0] fval(input int file, input int row, input int lane);
    return 24'((file + 1) * 24'h100000 + row * 256 + lane * 16 + 5);
  endfunction

  function automatic logic [95:0] fvec(input int file, input int row);
    logic [95:0] v;
    for (int c = 0; c < 4; c++) v[c*24 +: 24] = fval(file, row, c);
    return v;
  endfunction

  always_comb begin
    in_rd1  = fvec(0, int'(src1_row[3:0]));
    tmp_rd1 = fvec(1, int'(src1_row[3:0]));
    uni_rd1 = fvec(2, int'(src1_row));
    in_rd2  = fvec(0, int'(src2_row));
    tmp_rd2 = fvec(1, int'(src2_row));
  end

  // Reference state
  int          errors = 0;
  int          checks = 0;
  string       scen = "R10 reset";
  logic [21:0] m_tbl [32];
  int          m_ptr = 0;
  logic        e_valid = 1'b0;
  logic [95:0] e_op1 = '0, e_op2 = '0;
  logic [3:0]  e_wen = '0;
  logic [6:0]  e_dst = '0;
  logic        e_bad = 1'b0;
  string       e_tag1 = "R4";
  string       e_tag2 = "R6";

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%h expected=%h", req, scen, act, exp);
    end
  endtask

  function automatic logic [21:0] mkdesc(input logic [3:0] mask,
                                         input int a0, input int a1, input int a2, input int a3,
                                         input int b0, input int b1, input int b2, input int b3);
    logic [21:0] d = '0;
    d[3:0] = mask;
    d[12:11] = 2'(a0); d[10:9] = 2'(a1); d[8:7] = 2'(a2); d[6:5] = 2'(a3);
    d[21:20] = 2'(b0); d[19:18] = 2'(b1); d[17:16] = 2'(b2); d[15:14] = 2'(b3);
    return d;
  endfunction

  // One clock: check results of the previous step, drive, predict, update model
  task automatic cyc(input bit iss, input int id, input int s1, input int s2, input int dst,
                     input bit w, input int addr, input logic [21:0] data);
    @(negedge clk);
    chk("R9 op_valid", 96'(op_valid), 96'(e_valid));
    chk("R8 wr_en", 96'(wr_en), 96'(e_wen));
    chk("R5 bad_src1", 96'(bad_src1), 96'(e_bad));
    if (e_valid) begin
      chk({e_tag1, " R7 op1"}, op1, e_op1);
      chk({e_tag2, " R7 op2"}, op2, e_op2);
      chk("R9 op_dst", 96'(op_dst), 96'(e_dst));
    end
    issue_vld = iss; desc_id = 5'(id); src1_idx = 7'(s1); src2_idx = 5'(s2);
    dst_idx = 7'(dst); cfg_wr = w; cfg_addr = 4'(addr); cfg_wdata = data;
    e_valid = iss;
    if (iss) begin
      logic [21:0] d;
      int f1, r1, f2, r2;
      d = m_tbl[id];
      e_bad = 1'b0;
      if (s1 < 16)           begin f1 = 0; r1 = s1;      e_tag1 = "R4 input"; end
      else if (s1 < 32)      begin f1 = 1; r1 = s1 - 16; e_tag1 = "R4 temp"; end
      else if (s1 - 32 < 64) begin f1 = 2; r1 = s1 - 32; e_tag1 = "R4 uniform"; end
      else                   begin f1 = -1; r1 = 0; e_bad = 1'b1; e_tag1 = "R5 invalid"; end
      if (s2 < 16) begin f2 = 0; r2 = s2;      e_tag2 = "R6 input"; end
      else         begin f2 = 1; r2 = s2 - 16; e_tag2 = "R6 temp"; end
      for (int c = 0; c < 4; c++) begin
        int k1, k2;
        k1 = int'((d >> (11 - 2 * c)) & 22'd3);
        k2 = int'((d >> (20 - 2 * c)) & 22'd3);
        e_op1[c*24 +: 24] = (f1 < 0) ? 24'd0 : fval(f1, r1, k1);
        e_op2[c*24 +: 24] = fval(f2, r2, k2);
        e_wen[c] = d[3 - c];
      end
      e_dst = 7'(dst);
    end else begin
      e_wen = '0;
      e_bad = 1'b0;
    end
    if (w) begin
      if (addr == 0) m_ptr = 0;
      else if (addr >= 1 && addr <= 8) begin
        m_tbl[m_ptr] = data;
        m_ptr = (m_ptr + 1) % 32;
      end
    end
  endtask

  task automatic idle();
    cyc(1'b0, 0, 0, 0, 0, 1'b0, 0, '0);
  endtask

  task automatic put(input int addr, input logic [21:0] data);
    cyc(1'b0, 0, 0, 0, 0, 1'b1, addr, data);
  endtask

  task automatic issue(input int id, input int s1, input int s2, input int dst);
    cyc(1'b1, id, s1, s2, dst, 1'b0, 0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog [%s] actual=hung expected=done", scen);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m_tbl[i] = '0;
    // R10: state during and after reset
    repeat (2) @(negedge clk);
    chk("R10 op_valid", 96'(op_valid), 96'd0);
    chk("R10 wr_en", 96'(wr_en), 96'd0);
    chk("R10 bad_src1", 96'(bad_src1), 96'd0);
    chk("R10 op1", op1, '0);
    chk("R10 op2", op2, '0);
    rst_n = 1'b1;
    issue(7, 3, 4, 1);   // zeroed table: all lanes pick x, mask zero
    idle();

    // R1 R2: full fill through rotating aliases
    scen = "R1 R2 fill";
    put(0, '0);
    for (int i = 0; i < 32; i++) put(1 + (i % 8), 22'($urandom()));
    scen = "R3 R4 R6 R7 R8 sweep";
    for (int i = 0; i < 32; i++) issue(i, (i * 37) % 96, (i * 11) % 32, i);
    idle();

    // Directed swizzles and decode boundaries
    scen = "R1 R7 R8 directed";
    put(0, '0);
    put(1, mkdesc(4'b1111, 0, 1, 2, 3, 0, 1, 2, 3));
    put(2, mkdesc(4'b1000, 3, 2, 1, 0, 3, 3, 3, 3));
    put(3, mkdesc(4'b0001, 2, 2, 0, 1, 1, 0, 3, 2));
    scen = "R4 R5 R6 boundaries";
    issue(0, 8'h00, 5'h00, 1);
    issue(1, 8'h0F, 5'h0F, 2);
    issue(2, 8'h10, 5'h10, 3);
    issue(0, 8'h1F, 5'h1F, 4);
    issue(1, 8'h20, 5'h05, 5);
    issue(2, 8'h5F, 5'h1A, 6);
    issue(0, 8'h60, 5'h03, 7);
    issue(1, 8'h7F, 5'h12, 8);
    idle();

    // R2: ignored addresses do not touch table or pointer (pointer is at 3)
    scen = "R2 ignored addresses";
    for (int a = 9; a < 16; a++) put(a, 22'h3FFFFF);
    put(5, mkdesc(4'b0110, 1, 1, 1, 1, 2, 2, 2, 2));
    issue(3, 8'h21, 5'h11, 9);
    issue(4, 8'h02, 5'h02, 10);

    // R1: wrap after the last entry
    scen = "R1 wrap";
    put(0, '0);
    for (int i = 0; i < 33; i++) put(8, mkdesc(4'(i), i % 4, (i + 1) % 4, 0, 3, 1, 2, i % 4, 0));
    issue(0, 8'h11, 5'h01, 11);
    issue(1, 8'h11, 5'h01, 12);
    issue(31, 8'h11, 5'h01, 13);

    // R3: lookup of the entry written in the same cycle returns the old value
    scen = "R3 read before write";
    put(0, '0);
    cyc(1'b1, 0, 8'h22, 5'h13, 14, 1'b1, 4, mkdesc(4'b0101, 3, 3, 3, 3, 0, 0, 0, 0));
    issue(0, 8'h22, 5'h13, 15);
    idle();

    // R9: mixed random traffic with gaps
    scen = "R9 mixed";
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 2) put(int'($urandom_range(0, 15)), 22'($urandom()));
      else if (r < 3) idle();
      else issue(int'($urandom_range(0, 31)), int'($urandom_range(0, 127)),
                 int'($urandom_range(0, 31)), int'($urandom_range(0, 127)));
    end
    idle();
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule